// File: doc/BRIEF.md
# Pulse-Disciplined Capture Timestamp Clock

This block keeps a free-running 64-bit capture timestamp in fixed point. The upper half counts whole seconds since the start of 1970 and the lower half holds a binary fraction of a second in steps of 2^-32 s. The local crystal clock drives a 32-bit phase accumulator. Each carry out of that accumulator is one synthesized tick, and each tick adds 2^TICK_SHIFT to the fraction. With the default TICK_SHIFT of 8, a 2^24 Hz tick rate moves the clock at one second per second. The host loads the starting seconds value and tunes the accumulator increment. The frequency-correction loop itself runs on the host.

An external once-per-second reference pulse passes through a synchronizer. On every rising edge the block captures the signed offset of the timestamp from the nearest whole second. It judges that offset against a programmable health limit and keeps running counts of total pulses, bad pulses, isolated misses and the longest run of consecutive misses. When the block is set as master, it drives its own one-cycle pulse at every seconds rollover so that other capture clocks can follow it.

The host writes through a plain strobe interface: `wr_en` together with a 2-bit select and a 32-bit data word, taken at the next clock edge. There is no back-pressure on any pin. A write is always accepted, and the reference input is sampled every cycle.

Top module: `pps_stamp_clock`

## Requirements
- R1: While reset is held, the timestamp, the phase error, the error strobe, the health flag, all four counters and the pulse output are all zero.
- R2: A write with select 0 loads the data word into the seconds field and clears the fraction and the accumulator. The new timestamp `{data, 32'h0}` is visible in the cycle after the write edge.
- R3: A write with select 1 sets the accumulator increment, which is used from the following edge onward. Every accumulator carry adds 2^TICK_SHIFT to the fraction. With an increment of zero, the timestamp holds its value.
- R4: When the fraction wraps past one second, the seconds field increases by exactly one. Starting from a seconds load with increment 0xFFFFFFFF and TICK_SHIFT 24, the first rollover is visible 257 cycles after the load edge.
- R5: The rising edge of `pps_in` is registered by a two-flop synchronizer. On the third clock edge after the input rises, `phase_err` takes the fraction as a two's-complement value, and `err_valid` pulses for one cycle. A fraction at or above one half therefore reads as negative (early).
- R6: A write with select 2 sets the health threshold in fraction units; its reset value is 2560 (about 596 ns). At each pulse, `healthy` becomes 1 exactly when |phase error| <= threshold. A missed pulse clears it.
- R7: `pulse_bad` increases by one for each pulse whose |phase error| is greater than 2^30 (0.25 s). An error of exactly 2^30 is not bad.
- R8: `pulse_total` increases by one on each rising edge of the reference only. An input held high for several cycles counts once.
- R9: After the first pulse, a miss is counted once 1.5 s of ticks pass without a pulse, and then again after every further 1.0 s. `miss_longest` holds the largest number of consecutive misses seen. A pulse ends the current run.
- R10: `miss_single` increases by one when a pulse ends a run of exactly one miss.
- R11: Select 3 bit 0 sets master mode. In master mode, `pps_out` is high for exactly one cycle, in the cycle after each rollover. With master mode off, it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pps_in | input | 1 | Asynchronous once-per-second reference |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 seconds, 1 increment, 2 threshold, 3 control |
| wr_data | input | TS_W/2 | Register write data |
| timestamp | output | TS_W | Seconds in the upper half, binary fraction in the lower half |
| err_valid | output | 1 | One-cycle strobe when a new phase error is captured |
| phase_err | output | TS_W/2 | Signed offset from the nearest second, in fraction units |
| healthy | output | 1 | Last pulse was within the threshold and no miss has followed it |
| pulse_total | output | CNT_W | Reference edges seen (saturating) |
| pulse_bad | output | CNT_W | Pulses with offset above a quarter second (saturating) |
| miss_single | output | CNT_W | Runs of exactly one miss (saturating) |
| miss_longest | output | CNT_W | Longest run of consecutive misses |
| pps_out | output | 1 | Master pulse at each seconds rollover |

## Verification
A bad accumulator or step width shows up at once on `timestamp`: the fraction misses an exact target, or the first rollover lands on a cycle other than 257. A flaw in the synchronizer or capture path shows in `phase_err` and `err_valid` within three cycles of the reference rising. A flaw in the sign handling shows as a wrong `healthy` or `pulse_bad` value at the boundaries of a quarter second and of the threshold. A fault in the miss window stays hidden until about 1.5 s of ticks have passed, and then shows as a wrong run length or single count at the next pulse.

// File: rtl/pps_clk_pkg.sv
package pps_clk_pkg;
  typedef enum logic [1:0] {
    SEL_SECONDS = 2'd0,
    SEL_INCR    = 2'd1,
    SEL_THRESH  = 2'd2,
    SEL_CTRL    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pps_edge_sync.sv
module pps_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  // chain[STAGES-1] is the settled copy, chain[STAGES] its one-cycle delay
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], async_i};
  end

  assign rise_o = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/pps_phase_acc.sv
module pps_phase_acc #(
  parameter int ACC_W      = 32,
  parameter int SEC_W      = 32,
  parameter int FRAC_W     = 32,
  parameter int TICK_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ACC_W-1:0]  incr_i,
  input  logic              load_i,
  input  logic [SEC_W-1:0]  load_sec_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic              tick_o,
  output logic              roll_o
);
  localparam logic [FRAC_W:0] STEP = {{FRAC_W{1'b0}}, 1'b1} << TICK_SHIFT;

  logic [ACC_W-1:0]  acc_q;
  logic [ACC_W:0]    acc_sum;
  logic              carry;
  logic [FRAC_W:0]   frac_sum;
  logic              wrap;

  always_comb begin
    acc_sum  = {1'b0, acc_q} + {1'b0, incr_i};
    carry    = acc_sum[ACC_W];
    frac_sum = {1'b0, frac_o} + (carry ? STEP : '0);
    wrap     = frac_sum[FRAC_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      frac_o <= '0;
      sec_o  <= '0;
      tick_o <= 1'b0;
      roll_o <= 1'b0;
    end else if (load_i) begin
      acc_q  <= '0;
      frac_o <= '0;
      sec_o  <= load_sec_i;
      tick_o <= 1'b0;
      roll_o <= 1'b0;
    end else begin
      acc_q  <= acc_sum[ACC_W-1:0];
      frac_o <= frac_sum[FRAC_W-1:0];
      if (wrap) sec_o <= sec_o + 1'b1;
      tick_o <= carry;
      roll_o <= wrap;
    end
  end
endmodule

// File: rtl/pps_pulse_stats.sv
module pps_pulse_stats #(
  parameter int FRAC_W     = 32,
  parameter int TICK_SHIFT = 8,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_i,
  input  logic              tick_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic [FRAC_W-1:0] thresh_i,
  output logic              err_valid_o,
  output logic [FRAC_W-1:0] err_o,
  output logic              healthy_o,
  output logic [CNT_W-1:0]  total_o,
  output logic [CNT_W-1:0]  bad_o,
  output logic [CNT_W-1:0]  single_o,
  output logic [CNT_W-1:0]  longest_o
);
  localparam int TPS_LOG = FRAC_W - TICK_SHIFT;
  localparam int WIN_W   = TPS_LOG + 1;
  localparam logic [WIN_W-1:0] MISS_LAST  = (WIN_W'(3) << (TPS_LOG - 1)) - 1'b1;
  localparam logic [WIN_W-1:0] MISS_REARM = WIN_W'(1) << (TPS_LOG - 1);
  localparam logic [FRAC_W-1:0] BAD_LIM   = FRAC_W'(1) << (FRAC_W - 2);
  localparam logic [CNT_W-1:0]  CNT_MAX   = '1;

  logic [WIN_W-1:0]  win_q;
  logic              armed_q;
  logic [CNT_W-1:0]  run_q;
  logic [CNT_W-1:0]  run_next;
  logic [FRAC_W-1:0] mag;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  always_comb begin
    mag      = frac_i[FRAC_W-1] ? (~frac_i + 1'b1) : frac_i;
    run_next = sat_inc(run_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_valid_o <= 1'b0;
      err_o       <= '0;
      healthy_o   <= 1'b0;
      total_o     <= '0;
      bad_o       <= '0;
      single_o    <= '0;
      longest_o   <= '0;
      win_q       <= '0;
      armed_q     <= 1'b0;
      run_q       <= '0;
    end else begin
      err_valid_o <= rise_i;
      if (rise_i) begin
        err_o     <= frac_i;
        healthy_o <= (mag <= thresh_i);
        total_o   <= sat_inc(total_o);
        if (mag > BAD_LIM) bad_o <= sat_inc(bad_o);
        if (run_q == CNT_W'(1)) single_o <= sat_inc(single_o);
        run_q   <= '0;
        win_q   <= '0;
        armed_q <= 1'b1;
      end else if (armed_q && tick_i) begin
        if (win_q == MISS_LAST) begin
          win_q     <= MISS_REARM;
          run_q     <= run_next;
          healthy_o <= 1'b0;
          if (run_next > longest_o) longest_o <= run_next;
        end else begin
          win_q <= win_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pps_stamp_clock.sv
module pps_stamp_clock
  import pps_clk_pkg::*;
#(
  parameter int TS_W        = 64,
  parameter int TICK_SHIFT  = 8,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [TS_W/2-1:0] DEF_INC = 'd1441151881,
  parameter logic [TS_W/2-1:0] DEF_THR = 'd2560
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pps_in,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [TS_W/2-1:0] wr_data,
  output logic [TS_W-1:0]   timestamp,
  output logic              err_valid,
  output logic [TS_W/2-1:0] phase_err,
  output logic              healthy,
  output logic [CNT_W-1:0]  pulse_total,
  output logic [CNT_W-1:0]  pulse_bad,
  output logic [CNT_W-1:0]  miss_single,
  output logic [CNT_W-1:0]  miss_longest,
  output logic              pps_out
);
  localparam int HALF_W = TS_W / 2;

  logic [HALF_W-1:0] inc_q;
  logic [HALF_W-1:0] thr_q;
  logic              master_q;
  logic              sec_load;
  logic              pulse_edge;
  logic              tick;
  logic              roll;
  logic [HALF_W-1:0] sec;
  logic [HALF_W-1:0] frac;

  assign sec_load  = wr_en && (reg_sel_e'(wr_addr) == SEL_SECONDS);
  assign timestamp = {sec, frac};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_q    <= DEF_INC;
      thr_q    <= DEF_THR;
      master_q <= 1'b0;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_addr))
        SEL_INCR:   inc_q    <= wr_data;
        SEL_THRESH: thr_q    <= wr_data;
        SEL_CTRL:   master_q <= wr_data[0];
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pps_out <= 1'b0;
    else        pps_out <= roll & master_q;
  end

  pps_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pps_in),
    .rise_o  (pulse_edge)
  );

  pps_phase_acc #(
    .ACC_W      (HALF_W),
    .SEC_W      (HALF_W),
    .FRAC_W     (HALF_W),
    .TICK_SHIFT (TICK_SHIFT)
  ) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .incr_i     (inc_q),
    .load_i     (sec_load),
    .load_sec_i (wr_data),
    .sec_o      (sec),
    .frac_o     (frac),
    .tick_o     (tick),
    .roll_o     (roll)
  );

  pps_pulse_stats #(
    .FRAC_W     (HALF_W),
    .TICK_SHIFT (TICK_SHIFT),
    .CNT_W      (CNT_W)
  ) u_stats (
    .clk         (clk),
    .rst_n       (rst_n),
    .rise_i      (pulse_edge),
    .tick_i      (tick),
    .frac_i      (frac),
    .thresh_i    (thr_q),
    .err_valid_o (err_valid),
    .err_o       (phase_err),
    .healthy_o   (healthy),
    .total_o     (pulse_total),
    .bad_o       (pulse_bad),
    .single_o    (miss_single),
    .longest_o   (miss_longest)
  );
endmodule

// File: rtl/pps_clk_checker.sv
module pps_clk_checker #(
  parameter int TS_W  = 64,
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync_edge,
  input logic              err_valid,
  input logic              pps_out,
  input logic              sec_load,
  input logic [TS_W/2-1:0] inc_q,
  input logic [TS_W-1:0]   timestamp,
  input logic [CNT_W-1:0]  pulse_total,
  input logic [CNT_W-1:0]  miss_single,
  input logic [CNT_W-1:0]  miss_longest
);
  localparam int HALF_W = TS_W / 2;

  // R5: a synchronized edge yields a capture strobe on the next cycle
  a_r5_strobe_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    sync_edge |=> err_valid);

  // R5: no strobe without a preceding edge
  a_r5_no_spurious_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_edge |=> !err_valid);

  // R3: zero increment freezes the timestamp
  a_r3_hold_on_zero_incr: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_q == '0 && !sec_load) |=> $stable(timestamp));

  // R4: seconds move by at most one without a load
  a_r4_seconds_step: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_load |=> (timestamp[TS_W-1:HALF_W] == $past(timestamp[TS_W-1:HALF_W]) ||
                   timestamp[TS_W-1:HALF_W] == $past(timestamp[TS_W-1:HALF_W]) + 1'b1));

  // R11: master pulse lasts one cycle
  a_r11_pps_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pps_out |=> !pps_out);

  // R8: total never decreases
  a_r8_total_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_total >= $past(pulse_total));

  // R9: longest run never decreases
  a_r9_longest_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    miss_longest >= $past(miss_longest));

  // R10: every single miss is closed by a counted pulse
  a_r10_single_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    miss_single <= pulse_total);
endmodule

bind pps_stamp_clock pps_clk_checker #(.TS_W(TS_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sync_edge    (pulse_edge),
  .err_valid    (err_valid),
  .pps_out      (pps_out),
  .sec_load     (sec_load),
  .inc_q        (inc_q),
  .timestamp    (timestamp),
  .pulse_total  (pulse_total),
  .miss_single  (miss_single),
  .miss_longest (miss_longest)
);

// File: tb/tb_pps_stamp_clock.sv
module tb_pps_stamp_clock;
  localparam int TS_W = 64;
  localparam int TICK_SHIFT = 24;   // 256 ticks per second
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pps_in = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [63:0] timestamp;
  logic err_valid;
  logic [31:0] phase_err;
  logic healthy;
  logic [CNT_W-1:0] pulse_total, pulse_bad, miss_single, miss_longest;
  logic pps_out;

  pps_stamp_clock #(.TS_W(TS_W), .TICK_SHIFT(TICK_SHIFT), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .pps_in(pps_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .timestamp(timestamp), .err_valid(err_valid),
    .phase_err(phase_err), .healthy(healthy), .pulse_total(pulse_total),
    .pulse_bad(pulse_bad), .miss_single(miss_single), .miss_longest(miss_longest),
    .pps_out(pps_out));

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int pps_cnt = 0;
  int ev_cnt = 0;

  always @(negedge clk) begin
    if (pps_out) pps_cnt++;
    if (err_valid) ev_cnt++;
  end

  // {target fraction byte, threshold, expected healthy, expected bad}
  localparam logic [41:0] VEC [7] = '{
    {8'h00, 32'h0000_0000, 1'b1, 1'b0},
    {8'h02, 32'h0200_0000, 1'b1, 1'b0},
    {8'h40, 32'h0000_0000, 1'b0, 1'b0},
    {8'h41, 32'hFFFF_FFFF, 1'b1, 1'b1},
    {8'hC0, 32'h3FFF_FFFF, 1'b0, 1'b0},
    {8'hBF, 32'hFFFF_FFFF, 1'b1, 1'b1},
    {8'hFE, 32'h0200_0000, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse();
    pps_in = 1'b1;
    repeat (4) @(negedge clk);
    pps_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] held;
    logic [CNT_W-1:0] bad0;
    int ev0, p0, cyc;
    repeat (3) @(negedge clk);
    check("R1 timestamp", timestamp, 64'h0);
    check("R1 counters", {pulse_total, pulse_bad, miss_single, miss_longest}, 64'h0);
    check("R1 flags", {61'h0, healthy, err_valid, pps_out}, 64'h0);
    check("R1 phase_err", {32'h0, phase_err}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    wr(2'd1, 32'h0);
    wr(2'd0, 32'h1234_5678);
    check("R2 seconds load", timestamp, {32'h1234_5678, 32'h0});
    held = timestamp;
    repeat (40) @(negedge clk);
    check("R3 frozen with zero increment", timestamp, held);

    for (int i = 0; i < 7; i++) begin
      logic [7:0] tgt;
      tgt = VEC[i][41:34];
      wr(2'd1, 32'h0);
      wr(2'd0, 32'd500);
      wr(2'd2, VEC[i][33:2]);
      if (tgt != 8'h00) begin
        wr(2'd1, 32'hFFFF_FFFF);
        while (timestamp[31:0] != {tgt - 8'd1, 24'h0}) @(negedge clk);
        wr(2'd1, 32'h0);
      end
      check("R3 fraction step", timestamp, {32'd500, tgt, 24'h0});
      bad0 = pulse_bad;
      ev0 = ev_cnt;
      pulse();
      check("R5 phase error", {32'h0, phase_err}, {32'h0, tgt, 24'h0});
      check("R5 one strobe", 64'(ev_cnt - ev0), 64'd1);
      check("R6 healthy", {63'h0, healthy}, {63'h0, VEC[i][1]});
      check("R7 bad count", {48'h0, pulse_bad}, {48'h0, bad0 + CNT_W'(VEC[i][0])});
    end
    check("R8 total once per edge", {48'h0, pulse_total}, 64'd7);

    wr(2'd1, 32'hFFFF_FFFF);
    pulse();
    repeat (1000) @(negedge clk);
    check("R9 longest run", {48'h0, miss_longest}, 64'd3);
    check("R6 miss clears health", {63'h0, healthy}, 64'd0);
    pulse();
    check("R10 run of three not single", {48'h0, miss_single}, 64'd0);
    repeat (500) @(negedge clk);
    pulse();
    check("R10 single miss", {48'h0, miss_single}, 64'd1);
    check("R9 longest kept", {48'h0, miss_longest}, 64'd3);
    check("R8 total", {48'h0, pulse_total}, 64'd10);

    wr(2'd3, 32'h1);
    wr(2'd0, 32'd100);
    p0 = pps_cnt;
    cyc = 0;
    while (timestamp[63:32] != 32'd101) begin
      @(negedge clk);
      cyc++;
    end
    check("R4 first rollover cycle", 64'(cyc), 64'd257);
    check("R4 fraction wrapped", {32'h0, timestamp[31:0]}, 64'h0);
    while (timestamp[63:32] != 32'd102) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R11 master pulses", 64'(pps_cnt - p0), 64'd2);
    wr(2'd3, 32'h0);
    p0 = pps_cnt;
    while (timestamp[63:32] != 32'd103) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R11 no pulse when not master", 64'(pps_cnt - p0), 64'd0);

    summary();
    $finish;
  end
endmodule